// File: doc/BRIEF.md
# Dual-Bank Prioritized Interrupt Controller

The controller gathers 32 level inputs and presents them to two independent request lines: a normal line and a fast line. Every input first passes through one shared conditioning stage. A per-source polarity bit decides whether the input is inverted. A per-source mode bit picks either level behaviour or an edge-captured latch. Each of the two banks then applies its own enable mask and its own priority threshold. Each bank arbitrates among its qualified sources and reports the winning index.

Software reaches the block over a single-cycle register bus. The bus has separate read and write strobes, 32-bit data and an 8-bit word address. Read data is combinational and valid in the same cycle as the read strobe. A read of a bank's acknowledge register has a side effect: at the clock edge that ends the read, it releases the latch of the source that the register reported.

Word address map: bank A (normal line) uses words 0x00–0x3F and bank B (fast line) uses words 0x40–0x7F. Within a bank, the word offsets are:

| Offset | Register |
|---|---|
| 0x00 | qualified status |
| 0x01 | raw view |
| 0x02 | enable (write sets bits, read returns the mask) |
| 0x03 | disable (write clears bits) |
| 0x08 | current index |
| 0x0A | acknowledge |
| 0x0B | threshold |

The shared registers are the polarity register at word 0x80, the mode register at word 0x81, and the priorities of sources 0..31 at words 0xC0..0xDF.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset, both lines are low, both enable masks are 0, the polarity and mode registers are 0, all priorities are 0, and both thresholds read 0xF.
- R2: The conditioned level of source n is src_i[n] when polarity bit n is 1 and its inverse when the bit is 0. The raw view (offset 0x01) returns the 32 conditioned levels.
- R3: A write to offset 0x02 ORs the write data into the bank's enable mask. A write to offset 0x03 clears the mask bits where the data is 1. A read of 0x02 returns the mask.
- R4: Qualified status (offset 0x00) bit n is 1 exactly when source n is pending, enabled in that bank, and its priority value is at most the bank's threshold.
- R5: The current index (offset 0x08) is the qualified source with the smallest priority value. A tie goes to the lowest index. The index reads 0 when nothing is qualified.
- R6: A write to offset 0x0B sets the bank's 4-bit threshold. Sources whose priority value exceeds the threshold are excluded from status, the index and the line.
- R7: With mode bit n at 0, source n is pending exactly while its conditioned level is 1, with no memory.
- R8: With mode bit n at 1, a 0→1 transition of the conditioned level sets a latch. The latch keeps the source pending after the level falls.
- R9: A read of offset 0x0A returns the current index. At that clock edge it clears the latch of that source. A write to 0x0A has no effect.
- R10: Priority words 0xC0+n hold a 4-bit value, with 0 as the most urgent, and read back zero-extended.
- R11: irq_o (bank A) and fiq_o (bank B) each go high one clock after that bank's status becomes non-zero, and low one clock after it becomes zero. The banks act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt source levels |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle as rd_i |
| irq_o | output | 1 | Normal request line (bank A) |
| fiq_o | output | 1 | Fast request line (bank B) |

## Verification
The bench raises two sources with equal priority to confirm the tie goes to the lower index. A design that scanned from the top would report 7 instead of 6. It pushes the threshold below both priorities, which a design comparing with the wrong sense would miss by keeping the line high. It captures a short pulse on a latched source and shows that the source stays pending after the input drops, then shows that a bus write to the acknowledge word leaves it pending while a read releases it. A design that acknowledged on writes, or never cleared the latch, would show the wrong status. A behavioural model predicts both lines on every clock, which exposes an off-by-one in the output register or crosstalk between the banks.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // word offsets inside a bank window
  localparam int unsigned REG_STAT = 0;
  localparam int unsigned REG_RAW  = 1;
  localparam int unsigned REG_EN   = 2;
  localparam int unsigned REG_DIS  = 3;
  localparam int unsigned REG_CUR  = 8;
  localparam int unsigned REG_ACK  = 10;
  localparam int unsigned REG_THR  = 11;
  // offsets inside the shared window
  localparam int unsigned REG_POL  = 0;
  localparam int unsigned REG_MODE = 1;
  // address regions (top two address bits)
  localparam logic [1:0] RGN_SHARED = 2'd2;
  localparam logic [1:0] RGN_PRIO   = 2'd3;
endpackage

// File: rtl/intc_src_cond.sv
module intc_src_cond #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned N_BANK = 2,
  localparam int unsigned IW = $clog2(N_SRC)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_SRC-1:0]             src_i,
  input  logic [N_SRC-1:0]             pol_i,
  input  logic [N_SRC-1:0]             sticky_i,
  input  logic [N_BANK-1:0]            ack_i,
  input  logic [N_BANK-1:0][IW-1:0]    ack_idx_i,
  output logic [N_SRC-1:0]             raw_o,
  output logic [N_SRC-1:0]             pending_o
);
  logic [N_SRC-1:0] cond, cond_q, latch_q, clr;

  assign cond  = src_i ^ ~pol_i;
  assign raw_o = cond;

  always_comb begin
    clr = '0;
    for (int b = 0; b < int'(N_BANK); b++)
      if (ack_i[b]) clr[ack_idx_i[b]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q  <= '0;
      latch_q <= '0;
    end else begin
      cond_q  <= cond;
      // new edge wins over a same-cycle acknowledge
      latch_q <= ((latch_q & ~clr) | (cond & ~cond_q)) & sticky_i;
    end
  end

  assign pending_o = (sticky_i & latch_q) | (~sticky_i & cond);

  for (genvar n = 0; n < N_SRC; n++) begin : g_chk
    assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr[n] && sticky_i[n] && !(cond[n] && !cond_q[n])) |=> !latch_q[n]);
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned IW = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             req_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic [IW-1:0]                idx_o,
  output logic                         any_o
);
  logic [PRIO_W-1:0] best_p;

  // strict less-than keeps the lowest index on ties
  always_comb begin
    any_o  = 1'b0;
    best_p = '1;
    idx_o  = '0;
    for (int i = 0; i < int'(N_SRC); i++) begin
      if (req_i[i] && (!any_o || prio_i[i] < best_p)) begin
        any_o  = 1'b1;
        best_p = prio_i[i];
        idx_o  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IW = $clog2(N_SRC)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_SRC-1:0]             pending_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic                         en_set_i,
  input  logic                         en_clr_i,
  input  logic                         thr_we_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [N_SRC-1:0]             en_o,
  output logic [PRIO_W-1:0]            thr_o,
  output logic [N_SRC-1:0]             status_o,
  output logic [IW-1:0]                cur_o,
  output logic                         any_o,
  output logic                         line_o
);
  logic [N_SRC-1:0]  en_q;
  logic [PRIO_W-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      thr_q  <= '1;
      line_o <= 1'b0;
    end else begin
      if (en_set_i) en_q <= en_q | wdata_i[N_SRC-1:0];
      else if (en_clr_i) en_q <= en_q & ~wdata_i[N_SRC-1:0];
      if (thr_we_i) thr_q <= wdata_i[PRIO_W-1:0];
      line_o <= any_o;
    end
  end

  always_comb
    for (int n = 0; n < int'(N_SRC); n++)
      status_o[n] = pending_i[n] && en_q[n] && (prio_i[n] <= thr_q);

  intc_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .req_i (status_o),
    .prio_i(prio_i),
    .idx_o (cur_o),
    .any_o (any_o)
  );

  assign en_o  = en_q;
  assign thr_o = thr_q;

  assert_cur_qualified_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> status_o[cur_o]);
  assert_cur_below_thr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> (prio_i[cur_o] <= thr_q));
  assert_enable_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_set_i |=> ((en_q & $past(wdata_i[N_SRC-1:0])) == $past(wdata_i[N_SRC-1:0])));
  assert_disable_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_clr_i && !en_set_i) |=> ((en_q & $past(wdata_i[N_SRC-1:0])) == '0));
  assert_line_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_o) |-> $past(status_o != '0));
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int unsigned IW     = $clog2(N_SRC);
  localparam int unsigned N_BANK = 2;
  localparam int unsigned OFF_W  = ADDR_W - 2;

  logic [1:0]       region;
  logic [OFF_W-1:0] off;
  assign region = addr_i[ADDR_W-1 -: 2];
  assign off    = addr_i[OFF_W-1:0];

  logic [N_SRC-1:0]             pol_q, sticky_q, raw_w, pending_w;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;

  logic [N_BANK-1:0][N_SRC-1:0]  en_w, status_w;
  logic [N_BANK-1:0][PRIO_W-1:0] thr_w;
  logic [N_BANK-1:0][IW-1:0]     cur_w;
  logic [N_BANK-1:0]             any_w, line_w, ack_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q    <= '0;
      sticky_q <= '0;
      prio_q   <= '0;
    end else if (wr_i) begin
      if (region == RGN_SHARED && off == OFF_W'(REG_POL))  pol_q    <= wdata_i[N_SRC-1:0];
      if (region == RGN_SHARED && off == OFF_W'(REG_MODE)) sticky_q <= wdata_i[N_SRC-1:0];
      for (int n = 0; n < int'(N_SRC); n++)
        if (region == RGN_PRIO && off == OFF_W'(n)) prio_q[n] <= wdata_i[PRIO_W-1:0];
    end
  end

  intc_src_cond #(.N_SRC(N_SRC), .N_BANK(N_BANK)) u_cond (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .pol_i    (pol_q),
    .sticky_i (sticky_q),
    .ack_i    (ack_w),
    .ack_idx_i(cur_w),
    .raw_o    (raw_w),
    .pending_o(pending_w)
  );

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic sel;
    assign sel = (region == 2'(b));

    intc_bank #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pending_i(pending_w),
      .prio_i   (prio_q),
      .en_set_i (wr_i && sel && off == OFF_W'(REG_EN)),
      .en_clr_i (wr_i && sel && off == OFF_W'(REG_DIS)),
      .thr_we_i (wr_i && sel && off == OFF_W'(REG_THR)),
      .wdata_i  (wdata_i),
      .en_o     (en_w[b]),
      .thr_o    (thr_w[b]),
      .status_o (status_w[b]),
      .cur_o    (cur_w[b]),
      .any_o    (any_w[b]),
      .line_o   (line_w[b])
    );

    assign ack_w[b] = rd_i && sel && off == OFF_W'(REG_ACK) && any_w[b];
  end

  always_comb begin
    rdata_o = '0;
    case (region)
      RGN_SHARED: begin
        if (off == OFF_W'(REG_POL))  rdata_o = DATA_W'(pol_q);
        if (off == OFF_W'(REG_MODE)) rdata_o = DATA_W'(sticky_q);
      end
      RGN_PRIO: begin
        if (int'(off) < int'(N_SRC)) rdata_o = DATA_W'(prio_q[off[IW-1:0]]);
      end
      default: begin
        case (int'(off))
          REG_STAT:         rdata_o = DATA_W'(status_w[region[0]]);
          REG_RAW:          rdata_o = DATA_W'(raw_w);
          REG_EN:           rdata_o = DATA_W'(en_w[region[0]]);
          REG_CUR, REG_ACK: rdata_o = DATA_W'(cur_w[region[0]]);
          REG_THR:          rdata_o = DATA_W'(thr_w[region[0]]);
          default:          rdata_o = '0;
        endcase
      end
    endcase
  end

  assign irq_o = line_w[0];
  assign fiq_o = line_w[1];
endmodule

// File: tb/dual_bank_intc_tb.sv
module dual_bank_intc_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, fiq_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  dual_bank_intc dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // behavioural reference model
  bit [31:0] m_pol, m_stk, m_latch, m_condq;
  bit [31:0] m_en [2];
  int        m_thr [2];
  int        m_prio [32];
  bit        m_line [2];

  function automatic void m_qual(input int b, output bit [31:0] q, output int cur);
    bit [31:0] cond, pend;
    int best;
    cond = src_i ^ ~m_pol;
    pend = (m_stk & m_latch) | (~m_stk & cond);
    best = 99; cur = 0; q = '0;
    for (int n = 0; n < 32; n++) begin
      q[n] = pend[n] && m_en[b][n] && (m_prio[n] <= m_thr[b]);
      if (q[n] && m_prio[n] < best) begin best = m_prio[n]; cur = n; end
    end
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pol = '0; m_stk = '0; m_latch = '0; m_condq = '0;
      for (int b = 0; b < 2; b++) begin m_en[b] = '0; m_thr[b] = 15; m_line[b] = 1'b0; end
      for (int n = 0; n < 32; n++) m_prio[n] = 0;
    end else begin
      bit [31:0] q [2];
      int cur [2];
      bit [31:0] cond, clr;
      for (int b = 0; b < 2; b++) m_qual(b, q[b], cur[b]);
      cond = src_i ^ ~m_pol;
      clr = '0;
      for (int b = 0; b < 2; b++)
        if (rd_i && addr_i == 8'(b*64 + 10) && q[b] != 0) clr[cur[b]] = 1'b1;
      m_latch = ((m_latch & ~clr) | (cond & ~m_condq)) & m_stk;
      m_condq = cond;
      if (wr_i) begin
        for (int b = 0; b < 2; b++) begin
          if (addr_i == 8'(b*64 + 2))  m_en[b] = m_en[b] | wdata_i;
          if (addr_i == 8'(b*64 + 3))  m_en[b] = m_en[b] & ~wdata_i;
          if (addr_i == 8'(b*64 + 11)) m_thr[b] = int'(wdata_i[3:0]);
        end
        if (addr_i == 8'h80) m_pol = wdata_i;
        if (addr_i == 8'h81) m_stk = wdata_i;
        if (addr_i >= 8'hC0 && addr_i < 8'hE0) m_prio[addr_i - 8'hC0] = int'(wdata_i[3:0]);
      end
      for (int b = 0; b < 2; b++) m_line[b] = (q[b] != 0);
    end
  end

  // R11: both lines compared with the model on every clock
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      n_cmp++;
      if (irq_o !== m_line[0] || fiq_o !== m_line[1]) begin
        n_bad++;
        $display("FAIL R11 lines irq/fiq got %b%b exp %b%b", irq_o, fiq_o, m_line[0], m_line[1]);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk_i); rd_i = 1'b1; addr_i = a;
    #1 chk(tag, rdata_o, exp);
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic set_src(logic [31:0] v);
    @(negedge clk_i); src_i = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 32'd0);
    chk("R1 fiq", {31'b0, fiq_o}, 32'd0);
    rd(8'h0B, 32'hF, "R1 thr A");
    rd(8'h4B, 32'hF, "R1 thr B");
    rd(8'h02, 32'h0, "R1 en A");
    rd(8'h80, 32'h0, "R1 pol");
    rd(8'hC5, 32'h0, "R1 prio");
    // R2 polarity
    rd(8'h01, 32'hFFFF_FFFF, "R2 raw inverted");
    wr(8'h80, 32'hFFFF_FFFF);
    set_src(32'h5);
    rd(8'h01, 32'h5, "R2 raw passthrough");
    wr(8'h80, 32'hFFFF_FFFE);
    rd(8'h01, 32'h4, "R2 raw bit0 inverted");
    wr(8'h80, 32'hFFFF_FFFF);
    // R3 enable set/clear
    wr(8'h02, 32'hF0);
    wr(8'h03, 32'h30);
    rd(8'h02, 32'hC0, "R3 enable mask");
    // R4/R5 status and tie
    set_src(32'hFF);
    rd(8'h00, 32'hC0, "R4 status");
    rd(8'h08, 32'd6, "R5 tie lowest index");
    chk("R11 irq high", {31'b0, irq_o}, 32'd1);
    chk("R11 fiq low", {31'b0, fiq_o}, 32'd0);
    // R10 priorities
    wr(8'hC6, 32'hFFFF_FFF5);
    rd(8'hC6, 32'h5, "R10 prio readback");
    rd(8'h08, 32'd7, "R5 smaller value wins");
    wr(8'hC7, 32'h5);
    rd(8'h08, 32'd6, "R5 tie again");
    // R6 threshold
    wr(8'h0B, 32'h4);
    rd(8'h00, 32'h0, "R6 status gated");
    rd(8'h08, 32'd0, "R5 none qualified");
    chk("R6 irq low", {31'b0, irq_o}, 32'd0);
    wr(8'h0B, 32'hF);
    // bank B independent
    wr(8'h42, 32'h1);
    rd(8'h40, 32'h1, "R11 bank B status");
    rd(8'h00, 32'hC0, "R11 bank A unchanged");
    chk("R11 fiq high", {31'b0, fiq_o}, 32'd1);
    // R8 sticky latch
    wr(8'h81, 32'h100);
    wr(8'h02, 32'h100);
    set_src(32'h1FF);
    set_src(32'hFF);
    rd(8'h00, 32'h1C0, "R8 latched after drop");
    rd(8'h08, 32'd8, "R8 latched source current");
    // R7 level
    set_src(32'h7F);
    rd(8'h00, 32'h140, "R7 level follows input");
    // R9 acknowledge
    wr(8'h0A, 32'hFFFF_FFFF);
    rd(8'h00, 32'h140, "R9 write to ack ignored");
    rd(8'h0A, 32'd8, "R9 ack returns index");
    rd(8'h00, 32'h040, "R9 latch cleared");
    rd(8'h08, 32'd6, "R9 next current");
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule